// File: doc/BRIEF.md
# Static Memory Card Controller

This block is the control logic of a backplane card that carries up to 1 KB of static RAM. The card occupies one 1 KB window in a 64 KB address space. A six-bit position strap picks which window it answers to. Inside that window, the two address bits just above the byte offset pick one of four 256-byte banks. Only the first `POP_BANKS` banks are fitted. A read from an absent bank returns all ones, and a write to an absent bank is dropped.

The RAM is slow, so the card stretches every memory read it answers. It holds the bus ready line low (`rdy_hold` high) from the start-of-cycle pulse until a fixed number of phase-2 strokes have passed. The card also keeps one write-protect flip-flop. While that flip-flop is set, no write enable reaches the RAM. The protect state is reported on a status pin whenever the card is addressed.

The block also produces two driver enables. The read-data enable is active for memory reads to this card. The second enable is active when the card is addressed and the cycle is not an I/O cycle. All pins are plain control and status levels. The block has no handshake on its data path: the read-data output simply follows the address and the RAM data.

Top module: `memcard_ctrl`

## Requirements
- R1: `card_sel` is 1 exactly when `addr[15:10]` equals `strap_pos`.
- R2: `bank_sel` is the one-hot decode of `addr[9:8]` (bit n for value n) while `card_sel` is 1, and is all zero otherwise.
- R3: Banks with index `POP_BANKS` or above are absent. A read from an absent bank gives `rd_data` = 8'hFF, and a write to it raises no `ram_we` bit. For a present bank, `rd_data` equals `ram_rdata`. While the card is unselected, `rd_data` is 8'hFF.
- R4: A `sync_pulse` cycle in which `card_sel` and `stat_memr` are both 1 raises `rdy_hold` in that same cycle. `rdy_hold` then stays 1 until `WAIT_TICKS` later cycles with `ph2_tick` have occurred.
- R5: Every `sync_pulse` cycle restarts the wait count. A non-qualifying `sync_pulse` cycle clears the count, so `rdy_hold` is 0 in the following cycle. A qualifying one reloads the count to `WAIT_TICKS`.
- R6: In a cycle with `card_sel` = 1, `prot_req` sets the protect flip-flop and `unprot_req` clears it. If both are asserted, set wins. While `card_sel` = 0, both requests are ignored.
- R7: `ram_we[n]` is 1 only when `wr_strobe` = 1, bank n is selected and present, and the protect flip-flop is clear.
- R8: `prot_status` equals the protect flip-flop ANDed with `card_sel`.
- R9: `rd_drv_en` = `card_sel` AND `stat_memr`. `io_drv_en` = `card_sel` AND NOT `stat_inp` AND NOT `stat_out`.
- R10: After reset, the protect flip-flop is clear and the wait count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Bus address |
| strap_pos | input | 6 | Card window position strap |
| stat_memr | input | 1 | Latched status: memory read cycle |
| stat_inp | input | 1 | Latched status: input port cycle |
| stat_out | input | 1 | Latched status: output port cycle |
| sync_pulse | input | 1 | Start-of-machine-cycle pulse |
| ph2_tick | input | 1 | Phase-2 strobe that advances the wait count |
| wr_strobe | input | 1 | Memory write pulse from the bus |
| prot_req | input | 1 | Request to set write protect |
| unprot_req | input | 1 | Request to clear write protect |
| ram_rdata | input | 8 | Byte read from the selected RAM bank |
| card_sel | output | 1 | Card addressed |
| bank_sel | output | 4 | One-hot bank select |
| ram_off | output | 8 | Byte offset inside the bank |
| ram_we | output | 4 | Per-bank gated write enable |
| rd_data | output | 8 | Read data toward the bus (FF when absent or unselected) |
| rdy_hold | output | 1 | Pull the ready line low |
| prot_status | output | 1 | Protect state of the addressed card |
| rd_drv_en | output | 1 | Read-data driver enable |
| io_drv_en | output | 1 | Non-I/O selected driver enable |

## Verification
The bench goes after the following corner cases:
- A non-qualifying sync arriving mid-count. A design that only counted down would keep the bus stalled.
- A sync that coincides with a phase-2 strobe. A design that let the strobe win over the reload would shorten the wait by one stroke.
- Protect and unprotect requests arriving while the card is unselected. A design that ignored the select would change protect state from another card's traffic.
- Both requests asserted together.
- Writes to an absent bank. A design that ignored population would raise a write enable.
- Reads from an absent bank. A design that ignored population would return RAM data instead of all ones.

// File: rtl/memcard_pkg.sv
package memcard_pkg;
  typedef enum logic [1:0] {
    PA_KEEP = 2'd0,
    PA_SET  = 2'd1,
    PA_CLR  = 2'd2
  } prot_act_e;

  function automatic prot_act_e prot_action(input logic sel, input logic set_r, input logic clr_r);
    if (!sel)       return PA_KEEP;
    else if (set_r) return PA_SET;
    else if (clr_r) return PA_CLR;
    else            return PA_KEEP;
  endfunction
endpackage

// File: rtl/memcard_decode.sv
module memcard_decode #(
  parameter int HI_W      = 8,
  parameter int BANK_BITS = 2,
  parameter int POP_BANKS = 3,
  localparam int CARD_W   = HI_W - BANK_BITS,
  localparam int BANKS    = 1 << BANK_BITS
) (
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [CARD_W-1:0] strap_pos,
  output logic              card_sel,
  output logic [BANKS-1:0]  bank_sel,
  output logic [BANKS-1:0]  bank_live
);
  logic [BANK_BITS-1:0] idx;
  logic [BANKS-1:0]     pop_mask;

  assign card_sel = (addr_hi[HI_W-1:BANK_BITS] == strap_pos);
  assign idx      = addr_hi[BANK_BITS-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign pop_mask[b]  = (b < POP_BANKS) ? 1'b1 : 1'b0;
    assign bank_sel[b]  = card_sel && (idx == BANK_BITS'(b));
    assign bank_live[b] = bank_sel[b] && pop_mask[b];
  end
endmodule

// File: rtl/memcard_stall.sv
module memcard_stall #(
  parameter int WAIT_TICKS = 2,
  localparam int CNT_W     = $clog2(WAIT_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pulse,
  input  logic qualify,
  input  logic ph2_tick,
  output logic hold
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (sync_pulse) begin
      cnt <= qualify ? CNT_W'(WAIT_TICKS) : '0;
    end else if (ph2_tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign hold = (cnt != '0) || (sync_pulse && qualify);
endmodule

// File: rtl/memcard_protect.sv
module memcard_protect
  import memcard_pkg::*;
#(
  parameter int BANKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_sel,
  input  logic             prot_req,
  input  logic             unprot_req,
  input  logic             wr_strobe,
  input  logic [BANKS-1:0] bank_live,
  output logic             prot_q,
  output logic [BANKS-1:0] ram_we
);
  prot_act_e act;

  always_comb act = prot_action(card_sel, prot_req, unprot_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
    end else begin
      unique case (act)
        PA_SET:  prot_q <= 1'b1;
        PA_CLR:  prot_q <= 1'b0;
        default: prot_q <= prot_q;
      endcase
    end
  end

  assign ram_we = (wr_strobe && !prot_q) ? bank_live : '0;
endmodule

// File: rtl/memcard_ctrl.sv
module memcard_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int BANK_AW    = 8,
  parameter int BANK_BITS  = 2,
  parameter int POP_BANKS  = 3,
  parameter int WAIT_TICKS = 2,
  parameter int DATA_W     = 8,
  localparam int HI_W      = ADDR_W - BANK_AW,
  localparam int CARD_W    = HI_W - BANK_BITS,
  localparam int BANKS     = 1 << BANK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CARD_W-1:0] strap_pos,
  input  logic              stat_memr,
  input  logic              stat_inp,
  input  logic              stat_out,
  input  logic              sync_pulse,
  input  logic              ph2_tick,
  input  logic              wr_strobe,
  input  logic              prot_req,
  input  logic              unprot_req,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              card_sel,
  output logic [BANKS-1:0]  bank_sel,
  output logic [BANK_AW-1:0] ram_off,
  output logic [BANKS-1:0]  ram_we,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy_hold,
  output logic              prot_status,
  output logic              rd_drv_en,
  output logic              io_drv_en
);
  logic [BANKS-1:0] bank_live;
  logic             prot_q;

  memcard_decode #(
    .HI_W(HI_W), .BANK_BITS(BANK_BITS), .POP_BANKS(POP_BANKS)
  ) u_decode (
    .addr_hi  (addr[ADDR_W-1:BANK_AW]),
    .strap_pos(strap_pos),
    .card_sel (card_sel),
    .bank_sel (bank_sel),
    .bank_live(bank_live)
  );

  memcard_stall #(.WAIT_TICKS(WAIT_TICKS)) u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_pulse(sync_pulse),
    .qualify   (card_sel && stat_memr),
    .ph2_tick  (ph2_tick),
    .hold      (rdy_hold)
  );

  memcard_protect #(.BANKS(BANKS)) u_protect (
    .clk       (clk),
    .rst_n     (rst_n),
    .card_sel  (card_sel),
    .prot_req  (prot_req),
    .unprot_req(unprot_req),
    .wr_strobe (wr_strobe),
    .bank_live (bank_live),
    .prot_q    (prot_q),
    .ram_we    (ram_we)
  );

  assign ram_off     = addr[BANK_AW-1:0];
  assign rd_data     = (|bank_live) ? ram_rdata : {DATA_W{1'b1}};
  assign prot_status = prot_q && card_sel;
  assign rd_drv_en   = card_sel && stat_memr;
  assign io_drv_en   = card_sel && !stat_inp && !stat_out;
endmodule

// File: rtl/memcard_ctrl_chk.sv
module memcard_ctrl_chk #(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             card_sel,
  input logic [BANKS-1:0] bank_sel,
  input logic [BANKS-1:0] ram_we,
  input logic             prot_req,
  input logic             prot_status,
  input logic             sync_pulse,
  input logic             ph2_tick,
  input logic             stat_memr,
  input logic             rdy_hold,
  input logic             rd_drv_en
);
  p_onehot_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel) && ((|bank_sel) == card_sel));

  p_unsel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !card_sel |-> (ram_we == '0) && !prot_status && !rd_drv_en);

  p_we_in_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we & ~bank_sel) == '0);

  p_no_we_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_status |-> ram_we == '0);

  p_set_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (card_sel && prot_req) ##1 card_sel |-> prot_status);

  p_hold_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && card_sel && stat_memr) |-> rdy_hold);

  p_hold_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && card_sel && stat_memr) ##1 !sync_pulse |-> rdy_hold);

  p_hold_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_hold) |-> $past(ph2_tick || sync_pulse));

  p_drv_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drv_en |-> card_sel && stat_memr);
endmodule

bind memcard_ctrl memcard_ctrl_chk #(.BANKS(BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .card_sel   (card_sel),
  .bank_sel   (bank_sel),
  .ram_we     (ram_we),
  .prot_req   (prot_req),
  .prot_status(prot_status),
  .sync_pulse (sync_pulse),
  .ph2_tick   (ph2_tick),
  .stat_memr  (stat_memr),
  .rdy_hold   (rdy_hold),
  .rd_drv_en  (rd_drv_en)
);

// File: tb/memcard_ctrl_bench.sv
module memcard_ctrl_bench;
  localparam int PERIOD     = 10;
  localparam int POP_BANKS  = 3;
  localparam int WAIT_TICKS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [5:0] strap_pos = 6'd21;
  logic       stat_memr = 0, stat_inp = 0, stat_out = 0;
  logic       sync_pulse = 0, ph2_tick = 0, wr_strobe = 0;
  logic       prot_req = 0, unprot_req = 0;
  logic [7:0] ram_rdata;
  logic       card_sel, rdy_hold, prot_status, rd_drv_en, io_drv_en;
  logic [3:0] bank_sel, ram_we;
  logic [7:0] ram_off, rd_data;

  logic [7:0] mem [0:1023];
  logic [7:0] wdata = '0;
  int checks = 0, fails = 0;
  bit exp_prot = 0;
  int exp_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  assign ram_rdata = mem[{addr[9:8], addr[7:0]}];

  memcard_ctrl #(.POP_BANKS(POP_BANKS), .WAIT_TICKS(WAIT_TICKS)) u_memcard_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strap_pos(strap_pos),
    .stat_memr(stat_memr), .stat_inp(stat_inp), .stat_out(stat_out),
    .sync_pulse(sync_pulse), .ph2_tick(ph2_tick), .wr_strobe(wr_strobe),
    .prot_req(prot_req), .unprot_req(unprot_req), .ram_rdata(ram_rdata),
    .card_sel(card_sel), .bank_sel(bank_sel), .ram_off(ram_off), .ram_we(ram_we),
    .rd_data(rd_data), .rdy_hold(rdy_hold), .prot_status(prot_status),
    .rd_drv_en(rd_drv_en), .io_drv_en(io_drv_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit f_sel(input logic [15:0] a);
    return a[15:10] == strap_pos;
  endfunction

  function automatic bit f_live(input logic [15:0] a);
    return f_sel(a) && (int'(a[9:8]) < POP_BANKS);
  endfunction

  task automatic step(input logic [15:0] a, input bit sy, input bit p2, input bit mr,
                      input bit ip, input bit op, input bit wr, input bit pr, input bit up);
    bit sel, live, qual;
    logic [3:0] e_bank, e_we;
    logic [7:0] e_rd;
    addr = a; sync_pulse = sy; ph2_tick = p2; stat_memr = mr; stat_inp = ip;
    stat_out = op; wr_strobe = wr; prot_req = pr; unprot_req = up;
    wdata = 8'($urandom);
    #(PERIOD/4);
    sel = f_sel(a); live = f_live(a); qual = sy && sel && mr;
    e_bank = sel ? (4'b1 << a[9:8]) : 4'b0;
    e_we   = (wr && live && !exp_prot) ? e_bank : 4'b0;
    e_rd   = live ? mem[{a[9:8], a[7:0]}] : 8'hFF;
    chk(card_sel == sel, "R1 card_sel", 32'(card_sel), 32'(sel));
    chk(bank_sel == e_bank, "R2 bank_sel", 32'(bank_sel), 32'(e_bank));
    chk(rd_data == e_rd, "R3 rd_data", 32'(rd_data), 32'(e_rd));
    chk(rdy_hold == ((exp_cnt != 0) || qual), "R4 rdy_hold", 32'(rdy_hold),
        32'((exp_cnt != 0) || qual));
    chk(ram_we == e_we, "R7 ram_we", 32'(ram_we), 32'(e_we));
    chk(prot_status == (exp_prot && sel), "R8 prot_status", 32'(prot_status),
        32'(exp_prot && sel));
    chk(rd_drv_en == (sel && mr) && io_drv_en == (sel && !ip && !op), "R9 drivers",
        {30'd0, rd_drv_en, io_drv_en}, {30'd0, sel && mr, sel && !ip && !op});
    @(posedge clk);
    for (int b = 0; b < 4; b++) if (e_we[b]) mem[{2'(b), a[7:0]}] = wdata;
    if (sy) exp_cnt = qual ? WAIT_TICKS : 0;
    else if (p2 && exp_cnt > 0) exp_cnt--;
    if (sel && pr) exp_prot = 1;
    else if (sel && up) exp_prot = 0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick_addr(input int bank);
    return {strap_pos, 2'(bank), 8'($urandom)};
  endfunction

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state observed at the ports
    addr = pick_addr(0);
    #(PERIOD/4);
    chk(!prot_status && !rdy_hold && ram_we == 4'b0, "R10 reset state",
        {29'd0, prot_status, rdy_hold, |ram_we}, 32'd0);
    @(negedge clk);
    // R6: requests while unselected are ignored
    step(16'h0000, 0, 0, 0, 0, 0, 0, 1, 0);
    step(pick_addr(1), 0, 0, 0, 0, 0, 1, 0, 0);
    // R6: both requests at once -> set
    step(pick_addr(0), 0, 0, 0, 0, 0, 0, 1, 1);
    step(pick_addr(0), 0, 0, 0, 0, 0, 1, 0, 0);
    step(16'h0000, 0, 0, 0, 0, 0, 0, 0, 1);
    step(pick_addr(2), 0, 0, 0, 0, 0, 1, 0, 1);
    step(pick_addr(2), 0, 0, 1, 0, 0, 1, 0, 0);
    // R3: absent bank write then read
    step(pick_addr(3), 0, 0, 0, 0, 0, 1, 0, 0);
    step(pick_addr(3), 0, 0, 1, 0, 0, 0, 0, 0);
    // R4: qualifying sync, ticks with sync coincident phase-2
    step(pick_addr(1), 1, 1, 1, 0, 0, 0, 0, 0);
    step(pick_addr(1), 0, 0, 1, 0, 0, 0, 0, 0);
    step(pick_addr(1), 0, 1, 1, 0, 0, 0, 0, 0);
    step(pick_addr(1), 0, 0, 1, 0, 0, 0, 0, 0);
    step(pick_addr(1), 0, 1, 1, 0, 0, 0, 0, 0);
    step(pick_addr(1), 0, 1, 1, 0, 0, 0, 0, 0);
    // R5: non-qualifying sync mid-count clears it
    step(pick_addr(0), 1, 0, 1, 0, 0, 0, 0, 0);
    step(pick_addr(0), 1, 0, 0, 1, 0, 0, 0, 0);
    step(pick_addr(0), 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: qualifying reload while counting
    step(pick_addr(0), 1, 0, 1, 0, 0, 0, 0, 0);
    step(pick_addr(0), 0, 1, 1, 0, 0, 0, 0, 0);
    step(pick_addr(0), 1, 1, 1, 0, 0, 0, 0, 0);
    step(pick_addr(0), 0, 1, 1, 0, 0, 0, 0, 0);
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a = ($urandom_range(0, 9) < 7) ? pick_addr($urandom_range(0, 3)) : 16'($urandom);
      step(a, $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 15) == 0, $urandom_range(0, 11) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule